// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block is the hazard control of the decode stage in a five-stage in-order pipeline. It takes the two source register indices of the instruction in decode and compares them with the destination registers of the instructions now in execute and in memory access. For each source it picks the newest available value: the execute result, the access result, or the register-file read data. Each choice is captured in a register that drives the ALU input in the next cycle.

A load in execute has no data until the end of the access stage, so its result cannot reach a dependent instruction in decode in time. When decode reads a register that such a load will write, the block raises a stall in the same cycle, so that fetch and decode hold. It then loads a no-operation into the operand registers, and that bubble moves on down the pipeline. One cycle later the load has reached access, and the dependent instruction picks up the loaded value through the bypass path.

The register file is outside the block. It returns data being written in the same cycle, so a producer three instructions older needs no bypass. Register 0 always reads as zero.

Top module: `hazard_bypass_unit`

## Requirements
- R1: While reset is high, and after it is released until the first issue, `op_a_o`, `op_b_o`, `op_valid_o` and `bubble_o` are all 0.
- R2: When no older producer matches a source, that operand register captures the register-file read data at the next clock edge.
- R3: When the execute producer (valid, writing, not a load) has a destination equal to a nonzero source index, that operand captures `ex_result_i`.
- R4: When only the access producer (valid, writing) matches a nonzero source index, that operand captures `ma_result_i`.
- R5: When the execute and access producers both match a source, the execute result is chosen.
- R6: A source index of 0 yields operand value 0 whatever the read data and producer results are. It never causes forwarding or a stall, even when a load in execute targets register 0.
- R7: A producer whose valid flag or register-write flag is low is never forwarded from, and the register-file value is used.
- R8: `stall_o` is high in the same cycle in which a valid decode instruction has a nonzero source matching the destination of a valid, writing load in execute.
- R9: At the clock edge that ends a stall cycle, the operand registers load a NOP: `op_valid_o` becomes 0, both operands become 0, and `bubble_o` becomes 1 for that one cycle.
- R10: A load that has reached the access stage is forwarded through the access path without a stall.
- R11: `stall_o` stays low while `id_valid_i` is low. In that case `op_valid_o` becomes 0 at the next edge with `bubble_o` 0.
- R12: The two operands are steered independently: in the same cycle one can take the execute result while the other takes the access result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_rs1_i | input | 5 | First source register index |
| id_rs2_i | input | 5 | Second source register index |
| rf_rd1_i | input | 32 | Register-file read data for source 1 |
| rf_rd2_i | input | 32 | Register-file read data for source 2 |
| ex_valid_i | input | 1 | Execute stage holds a real instruction |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_rd_i | input | 5 | Execute destination index |
| ex_result_i | input | 32 | ALU result at the end of execute |
| ma_valid_i | input | 1 | Access stage holds a real instruction |
| ma_wen_i | input | 1 | Access instruction writes a register |
| ma_rd_i | input | 5 | Access destination index |
| ma_result_i | input | 32 | Loaded value or passed-on ALU result from access |
| stall_o | output | 1 | Hold fetch and decode this cycle |
| bubble_o | output | 1 | The operand registers hold an injected NOP |
| op_valid_o | output | 1 | The operand registers hold a real instruction |
| op_a_o | output | 32 | Registered first ALU operand |
| op_b_o | output | 32 | Registered second ALU operand |

## Verification
A wrong select or a wrong priority shows on `op_a_o` or `op_b_o` exactly one edge after the decode cycle, as a stale register-file value or an older producer's result. The stimulus therefore gives every source a distinct value, so that each possible choice is easy to tell apart. A missed interlock shows in the same cycle as a low `stall_o`. One edge later it shows as a valid operand where a NOP with `bubble_o` set was expected. Register 0 and disabled producers are driven with tempting matching values, so that any false forwarding changes the operand.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF   = 2'd0,
    SEL_EX   = 2'd1,
    SEL_MA   = 2'd2,
    SEL_ZERO = 2'd3
  } byp_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int RIDX = 5
) (
  input  logic [RIDX-1:0] src_i,
  input  logic            ex_valid_i,
  input  logic            ex_wen_i,
  input  logic            ex_load_i,
  input  logic [RIDX-1:0] ex_rd_i,
  input  logic            ma_valid_i,
  input  logic            ma_wen_i,
  input  logic [RIDX-1:0] ma_rd_i,
  output byp_sel_e        sel_o,
  output logic            load_hit_o
);
  logic src_zero, ex_hit, ma_hit;

  always_comb begin
    src_zero   = (src_i == '0);
    ex_hit     = !src_zero && ex_valid_i && ex_wen_i && (ex_rd_i == src_i);
    ma_hit     = !src_zero && ma_valid_i && ma_wen_i && (ma_rd_i == src_i);
    load_hit_o = ex_hit && ex_load_i;
    if (src_zero)    sel_o = SEL_ZERO;
    else if (ex_hit) sel_o = SEL_EX;   // youngest producer first
    else if (ma_hit) sel_o = SEL_MA;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/hz_operand_mux.sv
module hz_operand_mux
  import hz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  byp_sel_e        sel_i,
  input  logic [XLEN-1:0] rf_i,
  input  logic [XLEN-1:0] ex_i,
  input  logic [XLEN-1:0] ma_i,
  output logic [XLEN-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EX:  data_o = ex_i;
      SEL_MA:  data_o = ma_i;
      SEL_RF:  data_o = rf_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
  import hz_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int RIDX  = $clog2(NREG),
  parameter int NSRC  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            id_valid_i,
  input  logic [RIDX-1:0] id_rs1_i,
  input  logic [RIDX-1:0] id_rs2_i,
  input  logic [XLEN-1:0] rf_rd1_i,
  input  logic [XLEN-1:0] rf_rd2_i,
  input  logic            ex_valid_i,
  input  logic            ex_wen_i,
  input  logic            ex_load_i,
  input  logic [RIDX-1:0] ex_rd_i,
  input  logic [XLEN-1:0] ex_result_i,
  input  logic            ma_valid_i,
  input  logic            ma_wen_i,
  input  logic [RIDX-1:0] ma_rd_i,
  input  logic [XLEN-1:0] ma_result_i,
  output logic            stall_o,
  output logic            bubble_o,
  output logic            op_valid_o,
  output logic [XLEN-1:0] op_a_o,
  output logic [XLEN-1:0] op_b_o
);
  logic [NSRC-1:0][RIDX-1:0] src;
  logic [NSRC-1:0][XLEN-1:0] rf_data;
  logic [NSRC-1:0][XLEN-1:0] byp_data;
  logic [NSRC-1:0][XLEN-1:0] op_q;
  logic [NSRC-1:0]           load_hit;
  byp_sel_e                  sel [NSRC];

  assign src[0]     = id_rs1_i;
  assign src[1]     = id_rs2_i;
  assign rf_data[0] = rf_rd1_i;
  assign rf_data[1] = rf_rd2_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_match #(.RIDX(RIDX)) u_match (
      .src_i      (src[g]),
      .ex_valid_i (ex_valid_i),
      .ex_wen_i   (ex_wen_i),
      .ex_load_i  (ex_load_i),
      .ex_rd_i    (ex_rd_i),
      .ma_valid_i (ma_valid_i),
      .ma_wen_i   (ma_wen_i),
      .ma_rd_i    (ma_rd_i),
      .sel_o      (sel[g]),
      .load_hit_o (load_hit[g])
    );

    hz_operand_mux #(.XLEN(XLEN)) u_mux (
      .sel_i  (sel[g]),
      .rf_i   (rf_data[g]),
      .ex_i   (ex_result_i),
      .ma_i   (ma_result_i),
      .data_o (byp_data[g])
    );

    always_ff @(posedge clk) begin
      if (rst || stall_o) op_q[g] <= '0;
      else                op_q[g] <= byp_data[g];
    end
  end

  // Interlock: load data in execute cannot travel back to decode in time.
  assign stall_o = id_valid_i && (|load_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid_o <= 1'b0;
      bubble_o   <= 1'b0;
    end else begin
      op_valid_o <= id_valid_i && !stall_o;
      bubble_o   <= stall_o;
    end
  end

  assign op_a_o = op_q[0];
  assign op_b_o = op_q[1];

  AST_STALL_NEEDS_ID: assert property (@(posedge clk) disable iff (rst)
    !id_valid_i |-> !stall_o); // R11

  AST_STALL_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (ex_valid_i && ex_wen_i && ex_load_i && ex_rd_i != '0)); // R8

  AST_STALL_GIVES_NOP: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (bubble_o && !op_valid_o && op_a_o == '0 && op_b_o == '0)); // R9

  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    (!stall_o && id_rs1_i == '0) |=> (op_a_o == '0)); // R6

  AST_EX_WINS: assert property (@(posedge clk) disable iff (rst)
    (!stall_o && id_rs1_i != '0 && ex_valid_i && ex_wen_i && ex_rd_i == id_rs1_i)
      |=> (op_a_o == $past(ex_result_i))); // R5

  AST_MA_FWD: assert property (@(posedge clk) disable iff (rst)
    (!stall_o && id_rs2_i != '0 && ma_valid_i && ma_wen_i && ma_rd_i == id_rs2_i &&
     !(ex_valid_i && ex_wen_i && ex_rd_i == id_rs2_i))
      |=> (op_b_o == $past(ma_result_i))); // R4
endmodule

// File: tb/hazard_bypass_unit_tb.sv
module hazard_bypass_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        id_valid_i;
  logic [4:0]  id_rs1_i, id_rs2_i;
  logic [31:0] rf_rd1_i, rf_rd2_i;
  logic        ex_valid_i, ex_wen_i, ex_load_i;
  logic [4:0]  ex_rd_i;
  logic [31:0] ex_result_i;
  logic        ma_valid_i, ma_wen_i;
  logic [4:0]  ma_rd_i;
  logic [31:0] ma_result_i;
  logic        stall_o, bubble_o, op_valid_o;
  logic [31:0] op_a_o, op_b_o;

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic        v;
    logic        bub;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #5 clk = ~clk;

  hazard_bypass_unit u_dut (
    .clk(clk), .rst(rst),
    .id_valid_i(id_valid_i), .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i),
    .rf_rd1_i(rf_rd1_i), .rf_rd2_i(rf_rd2_i),
    .ex_valid_i(ex_valid_i), .ex_wen_i(ex_wen_i), .ex_load_i(ex_load_i),
    .ex_rd_i(ex_rd_i), .ex_result_i(ex_result_i),
    .ma_valid_i(ma_valid_i), .ma_wen_i(ma_wen_i), .ma_rd_i(ma_rd_i),
    .ma_result_i(ma_result_i),
    .stall_o(stall_o), .bubble_o(bubble_o), .op_valid_o(op_valid_o),
    .op_a_o(op_a_o), .op_b_o(op_b_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(logic [4:0] idx, logic [31:0] rf);
    if (idx == 5'd0) return 32'h0;
    if (ex_valid_i && ex_wen_i && ex_rd_i == idx) return ex_result_i;
    if (ma_valid_i && ma_wen_i && ma_rd_i == idx) return ma_result_i;
    return rf;
  endfunction

  // Driver: apply one decode cycle, check stall now, queue expected registered result.
  task automatic drive(string tag,
                       logic idv, logic [4:0] r1, logic [4:0] r2,
                       logic [31:0] d1, logic [31:0] d2,
                       logic exv, logic exw, logic exl, logic [4:0] exd, logic [31:0] exr,
                       logic mav, logic maw, logic [4:0] mad, logic [31:0] mar);
    exp_t e;
    logic st;
    @(negedge clk);
    id_valid_i = idv; id_rs1_i = r1; id_rs2_i = r2; rf_rd1_i = d1; rf_rd2_i = d2;
    ex_valid_i = exv; ex_wen_i = exw; ex_load_i = exl; ex_rd_i = exd; ex_result_i = exr;
    ma_valid_i = mav; ma_wen_i = maw; ma_rd_i = mad; ma_result_i = mar;
    #1;
    st = idv && exv && exw && exl &&
         ((r1 != 0 && r1 == exd) || (r2 != 0 && r2 == exd));
    check({tag, " stall"}, {31'b0, stall_o}, {31'b0, st});
    e.tag = tag;
    e.bub = st;
    e.v   = idv && !st;
    e.a   = st ? 32'h0 : pick(r1, d1);
    e.b   = st ? 32'h0 : pick(r2, d2);
    exp_q.push_back(e);
  endtask

  // Monitor: compare registered outputs after each edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.tag, " op_a"},   op_a_o, e.a);
      check({e.tag, " op_b"},   op_b_o, e.b);
      check({e.tag, " valid"},  {31'b0, op_valid_o}, {31'b0, e.v});
      check({e.tag, " bubble"}, {31'b0, bubble_o},   {31'b0, e.bub});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    id_valid_i = 0; id_rs1_i = 0; id_rs2_i = 0; rf_rd1_i = 0; rf_rd2_i = 0;
    ex_valid_i = 0; ex_wen_i = 0; ex_load_i = 0; ex_rd_i = 0; ex_result_i = 0;
    ma_valid_i = 0; ma_wen_i = 0; ma_rd_i = 0; ma_result_i = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset op_a", op_a_o, 32'h0);
    check("R1 reset op_b", op_b_o, 32'h0);
    check("R1 reset valid", {31'b0, op_valid_o}, 32'h0);
    check("R1 reset bubble", {31'b0, bubble_o}, 32'h0);
    @(negedge clk); rst = 1'b0;

    drive("R2 no match", 1, 5'd3, 5'd4, 32'hA1A1_0003, 32'hB2B2_0004,
          1, 1, 0, 5'd5, 32'hEEEE_0005, 1, 1, 5'd6, 32'hCCCC_0006);
    drive("R3 ex fwd a", 1, 5'd9, 5'd4, 32'h1111_0009, 32'h2222_0004,
          1, 1, 0, 5'd9, 32'hE0E0_0009, 1, 1, 5'd6, 32'hC0C0_0006);
    drive("R4 ma fwd b", 1, 5'd3, 5'd12, 32'h3333_0003, 32'h4444_000C,
          1, 1, 0, 5'd5, 32'hE1E1_0005, 1, 1, 5'd12, 32'hC1C1_000C);
    drive("R5 ex beats ma", 1, 5'd7, 5'd7, 32'h5555_0007, 32'h6666_0007,
          1, 1, 0, 5'd7, 32'hE2E2_0007, 1, 1, 5'd7, 32'hC2C2_0007);
    drive("R6 zero src", 1, 5'd0, 5'd0, 32'hDEAD_BEEF, 32'hFEED_FACE,
          1, 1, 0, 5'd0, 32'hE3E3_0000, 1, 1, 5'd0, 32'hC3C3_0000);
    drive("R6 zero src load", 1, 5'd0, 5'd8, 32'h1234_5678, 32'h8888_0008,
          1, 1, 1, 5'd0, 32'hE4E4_0000, 0, 0, 5'd0, 32'h0);
    drive("R7 ex invalid", 1, 5'd10, 5'd11, 32'h7777_000A, 32'h9999_000B,
          0, 1, 0, 5'd10, 32'hE5E5_000A, 1, 0, 5'd11, 32'hC5C5_000B);
    drive("R7 ex no wen", 1, 5'd13, 5'd13, 32'hABAB_000D, 32'hCDCD_000D,
          1, 0, 0, 5'd13, 32'hE6E6_000D, 0, 1, 5'd13, 32'hC6C6_000D);
    drive("R8 R9 load use", 1, 5'd2, 5'd14, 32'h0202_0002, 32'h0E0E_000E,
          1, 1, 1, 5'd14, 32'hE7E7_000E, 1, 1, 5'd2, 32'hC7C7_0002);
    drive("R10 load in ma", 1, 5'd2, 5'd14, 32'h0202_0002, 32'h0E0E_000E,
          0, 0, 0, 5'd0, 32'h0, 1, 1, 5'd14, 32'hDADA_000E);
    drive("R8 R9 load use a", 1, 5'd15, 5'd1, 32'h0F0F_000F, 32'h0101_0001,
          1, 1, 1, 5'd15, 32'hE8E8_000F, 0, 0, 5'd0, 32'h0);
    drive("R11 idle no stall", 0, 5'd16, 5'd17, 32'h1010_0010, 32'h1111_0011,
          1, 1, 1, 5'd16, 32'hE9E9_0010, 0, 0, 5'd0, 32'h0);
    drive("R12 split", 1, 5'd18, 5'd19, 32'h1212_0012, 32'h1313_0013,
          1, 1, 0, 5'd18, 32'hEAEA_0012, 1, 1, 5'd19, 32'hCACA_0013);
    drive("R12 split swap", 1, 5'd21, 5'd20, 32'h1515_0015, 32'h1414_0014,
          1, 1, 0, 5'd20, 32'hEBEB_0014, 1, 1, 5'd21, 32'hCBCB_0015);
    drive("R2 tail", 1, 5'd31, 5'd30, 32'h1F1F_001F, 32'h1E1E_001E,
          0, 0, 0, 5'd0, 32'h0, 0, 0, 5'd0, 32'h0);
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule